// File: doc/BRIEF.md
# Ingress Control Word Decoder and Port Dispatcher

This block sits behind the word-alignment and parity stages of a 16-bit packet-over-lanes receiver. It takes one word per cycle, each with a flag that marks it as control or data. It also takes an indication that the link is in sync. Each control word is classified by its upper nibble. The block enforces the rule that payload control words and data words come in the right order. Each payload burst is steered to a destination that is looked up from its 8-bit logical port number.

The lookup uses a 256-entry map. Each entry holds a destination index and an active flag, and a simple write port programs it. Bursts for active ports are forwarded one word at a time. Each word carries a start-of-packet tag, an end-of-packet tag, a running byte length and a packet-error tag.

The end-of-packet status arrives in the control word that follows a burst. For that reason the block holds back the most recent data word until the next word shows whether it was the last one. Bursts for inactive ports are dropped. Each one raises an event pulse and records its port number. Ordering violations and reserved control codes raise a bus-error pulse.

Top module: `ctl_word_dispatch`

## Requirements
- R1: A control word with bit 15 clear and bit 12 set (upper nibble 0001, 0011, 0101 or 0111) is reserved. It raises `bus_err` for one cycle, in the cycle after it is accepted, and has no other effect. A control word with bit 15 set is a payload control word. A control word with bits 15 and 12 both clear is an idle control word.
- R2: A control word of any kind that arrives directly after a payload control word, with no data word between them, raises `bus_err` in the cycle after it is accepted.
- R3: A data word that arrives when no burst is open (after reset, after an idle control word, or after a loss of sync) raises `bus_err` in the cycle after it is accepted. The word is discarded.
- R4: A payload control word takes its port from bits [11:4]. If the map entry for that port is active, each following data word is released on `out_*` with that entry's destination. A word is released one cycle after the accepted word that follows it: a data word in the same burst, or an idle or payload control word.
- R5: Bit 12 of a payload control word is the SOP flag. When it is set, `out_sop` is set on the first data word of that burst only.
- R6: Bits [14:13] of an idle or payload control word give the end status of the preceding burst: 00 means no end, 01 means the packet ended in abort, 10 means it ended with two valid bytes, and 11 means it ended with one valid byte. Any nonzero status sets `out_eop` on the last data word of that burst.
- R7: `out_len` is the running byte count of the burst, including the word on the output. Each word adds 2 bytes. A final word with end status 11 adds only 1.
- R8: After an end status of 01, every word of the next packet to start (the next active payload control word with SOP) carries `out_err`. The packet after that is clean again.
- R9: A payload control word for an inactive port pulses `inact_evt` in the cycle after it is accepted, and `inact_port` takes its port number. The data words of that burst are dropped without a bus error.
- R10: While `in_sync` is low, words are ignored and no output or event is produced. The held word is dropped, and the open burst and any pending abort mark are cleared.
- R11: A map write through `map_we` takes effect for control words accepted after the write's clock edge.
- R12: After reset all map entries are inactive, all outputs are zero, and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A word is present this cycle |
| in_ctl | input | 1 | The word is a control word |
| in_sync | input | 1 | Link is in the synchronized state |
| in_word | input | 16 | Incoming word |
| map_we | input | 1 | Write one map entry |
| map_port | input | 8 | Map entry to write |
| map_active | input | 1 | Active flag to write |
| map_dest | input | DEST_W | Destination index to write |
| out_valid | output | 1 | Dispatched data word present |
| out_data | output | 16 | Dispatched data word |
| out_dest | output | DEST_W | Destination of the word |
| out_sop | output | 1 | First word of a packet |
| out_eop | output | 1 | Last word of a packet |
| out_len | output | LEN_W | Running byte count of the burst |
| out_err | output | 1 | Packet is marked errored |
| bus_err | output | 1 | Bus-error event pulse |
| inact_evt | output | 1 | Inactive-port transfer event pulse |
| inact_port | output | 8 | Port of the last inactive transfer |

## Verification
The bench builds the block with DEST_W = 3 and LEN_W = 16. Three bits are enough to give each of the 256 ports a destination derived from its own number. With every third port inactive, one sweep over the whole map covers every entry, both active states and both one-byte and two-byte endings. The eight upper-nibble values a non-payload control word can take are swept to cover the reserved codes. Short fixed sequences cover multi-word bursts, burst continuations, abort marking, ordering violations, map rewrites and loss of sync.

// File: rtl/cwd_pkg.sv
package cwd_pkg;

  localparam int PORT_W    = 8;
  localparam int NUM_PORTS = 1 << PORT_W;
  localparam int WORD_W    = 16;

  typedef enum logic [1:0] {
    WC_DATA     = 2'd0,
    WC_IDLE     = 2'd1,
    WC_PAYLOAD  = 2'd2,
    WC_RESERVED = 2'd3
  } word_class_t;

  typedef enum logic [1:0] {
    EOP_NONE  = 2'b00,
    EOP_ABORT = 2'b01,
    EOP_TWO   = 2'b10,
    EOP_ONE   = 2'b11
  } eop_t;

  // Upper nibble of a control word: bit 3 marks payload, bit 0 without bit 3 is reserved
  function automatic logic type_reserved(input logic [3:0] t);
    return !t[3] && t[0];
  endfunction

  function automatic logic ends_packet(input eop_t c);
    return c != EOP_NONE;
  endfunction

  // Running length after accepting one more data word
  function automatic logic [31:0] step_len(input logic first, input logic [31:0] prev);
    return first ? 32'd2 : prev + 32'd2;
  endfunction

  // Length presented on the closing word of a burst
  function automatic logic [31:0] closing_len(input logic [31:0] run, input eop_t c);
    return (c == EOP_ONE) ? run - 32'd1 : run;
  endfunction

endpackage

// File: rtl/cwd_classify.sv
module cwd_classify
  import cwd_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic              ctl,
  output word_class_t       cls,
  output eop_t              code,
  output logic [PORT_W-1:0] port,
  output logic              sop_bit
);

  logic unused_low;
  assign unused_low = ^word[3:0];

  always_comb begin
    if (!ctl)                          cls = WC_DATA;
    else if (type_reserved(word[15:12])) cls = WC_RESERVED;
    else if (word[15])                 cls = WC_PAYLOAD;
    else                               cls = WC_IDLE;
  end

  assign code    = eop_t'(word[14:13]);
  assign port    = word[11:4];
  assign sop_bit = word[12];

endmodule

// File: rtl/cwd_port_map.sv
module cwd_port_map
  import cwd_pkg::*;
#(
  parameter int DEST_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PORT_W-1:0] waddr,
  input  logic              wactive,
  input  logic [DEST_W-1:0] wdest,
  input  logic [PORT_W-1:0] raddr,
  output logic              ractive,
  output logic [DEST_W-1:0] rdest
);

  logic [NUM_PORTS-1:0] act_q;
  logic [DEST_W-1:0]    dest_q [NUM_PORTS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= '0;
    end else if (we) begin
      act_q[waddr] <= wactive;
    end
  end

  always_ff @(posedge clk) begin
    if (we) dest_q[waddr] <= wdest;
  end

  assign ractive = act_q[raddr];
  assign rdest   = ractive ? dest_q[raddr] : '0;

endmodule

// File: rtl/cwd_sequencer.sv
module cwd_sequencer
  import cwd_pkg::*;
#(
  parameter int DEST_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sync,
  input  word_class_t       cls,
  input  eop_t              code,
  input  logic              sop_bit,
  input  logic [PORT_W-1:0] port,
  input  logic              map_active,
  input  logic [DEST_W-1:0] map_dest,
  output logic              take,
  output logic              take_first,
  output logic              take_sop,
  output logic              take_err,
  output logic [DEST_W-1:0] take_dest,
  output logic              close,
  output logic              burst_open,
  output logic              need_data,
  output logic              bus_err,
  output logic              inact_evt,
  output logic [PORT_W-1:0] inact_port
);

  logic              acc;
  logic              open_q, need_q, live_q, first_q, sop_q, abort_q, pkt_err_q;
  logic [DEST_W-1:0] dest_q;
  logic              ev_reserved, ev_missing, ev_orphan, ev_inactive;
  logic              abort_next;

  assign acc         = in_valid && in_sync;
  assign ev_reserved = acc && (cls == WC_RESERVED);
  assign ev_missing  = acc && (cls != WC_DATA) && need_q;
  assign ev_orphan   = acc && (cls == WC_DATA) && !open_q;
  assign ev_inactive = acc && (cls == WC_PAYLOAD) && !map_active;
  assign abort_next  = abort_q || (code == EOP_ABORT);

  assign take       = acc && (cls == WC_DATA) && open_q && live_q;
  assign take_first = first_q;
  assign take_sop   = sop_q;
  assign take_err   = pkt_err_q;
  assign take_dest  = dest_q;
  assign close      = acc && ((cls == WC_IDLE) || (cls == WC_PAYLOAD));
  assign burst_open = open_q;
  assign need_data  = need_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q     <= 1'b0;
      need_q     <= 1'b0;
      live_q     <= 1'b0;
      first_q    <= 1'b0;
      sop_q      <= 1'b0;
      abort_q    <= 1'b0;
      pkt_err_q  <= 1'b0;
      dest_q     <= '0;
      bus_err    <= 1'b0;
      inact_evt  <= 1'b0;
      inact_port <= '0;
    end else begin
      bus_err   <= ev_reserved || ev_missing || ev_orphan;
      inact_evt <= ev_inactive;
      if (ev_inactive) inact_port <= port;
      if (!in_sync) begin
        open_q  <= 1'b0;
        need_q  <= 1'b0;
        live_q  <= 1'b0;
        first_q <= 1'b0;
        sop_q   <= 1'b0;
        abort_q <= 1'b0;
      end else if (in_valid) begin
        unique case (cls)
          WC_DATA: begin
            need_q <= 1'b0;
            if (take) begin
              first_q <= 1'b0;
              sop_q   <= 1'b0;
            end
          end
          WC_IDLE: begin
            open_q  <= 1'b0;
            need_q  <= 1'b0;
            live_q  <= 1'b0;
            first_q <= 1'b0;
            sop_q   <= 1'b0;
            abort_q <= abort_next;
          end
          WC_PAYLOAD: begin
            open_q  <= 1'b1;
            need_q  <= 1'b1;
            live_q  <= map_active;
            dest_q  <= map_dest;
            first_q <= 1'b1;
            sop_q   <= sop_bit && map_active;
            if (map_active && sop_bit) begin
              pkt_err_q <= abort_next;
              abort_q   <= 1'b0;
            end else begin
              abort_q   <= abort_next;
            end
          end
          WC_RESERVED: begin
            need_q <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/cwd_stager.sv
module cwd_stager
  import cwd_pkg::*;
#(
  parameter int DEST_W = 4,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drop,
  input  logic              take,
  input  logic              take_first,
  input  logic              take_sop,
  input  logic              take_err,
  input  logic [DEST_W-1:0] take_dest,
  input  logic [WORD_W-1:0] take_data,
  input  logic              close,
  input  eop_t              close_code,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic [DEST_W-1:0] out_dest,
  output logic              out_sop,
  output logic              out_eop,
  output logic [LEN_W-1:0]  out_len,
  output logic              out_err
);

  logic              held_v, held_sop, held_err;
  logic [WORD_W-1:0] held_data;
  logic [DEST_W-1:0] held_dest;
  logic [LEN_W-1:0]  held_len;
  logic              emit_mid, emit_end;

  assign emit_mid = take && held_v;
  assign emit_end = close && held_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_v    <= 1'b0;
      held_sop  <= 1'b0;
      held_err  <= 1'b0;
      held_data <= '0;
      held_dest <= '0;
      held_len  <= '0;
    end else if (drop) begin
      held_v <= 1'b0;
    end else if (take) begin
      held_v    <= 1'b1;
      held_sop  <= take_sop;
      held_err  <= take_err;
      held_data <= take_data;
      held_dest <= take_dest;
      held_len  <= LEN_W'(step_len(take_first, 32'(held_len)));
    end else if (close) begin
      held_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_dest  <= '0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_len   <= '0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= (emit_mid || emit_end) && !drop;
      if ((emit_mid || emit_end) && !drop) begin
        out_data <= held_data;
        out_dest <= held_dest;
        out_sop  <= held_sop;
        out_err  <= held_err;
        out_eop  <= emit_end && ends_packet(close_code);
        out_len  <= emit_end ? LEN_W'(closing_len(32'(held_len), close_code)) : held_len;
      end
    end
  end

endmodule

// File: rtl/ctl_word_dispatch.sv
module ctl_word_dispatch
  import cwd_pkg::*;
#(
  parameter int DEST_W = 4,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_ctl,
  input  logic              in_sync,
  input  logic [15:0]       in_word,
  input  logic              map_we,
  input  logic [7:0]        map_port,
  input  logic              map_active,
  input  logic [DEST_W-1:0] map_dest,
  output logic              out_valid,
  output logic [15:0]       out_data,
  output logic [DEST_W-1:0] out_dest,
  output logic              out_sop,
  output logic              out_eop,
  output logic [LEN_W-1:0]  out_len,
  output logic              out_err,
  output logic              bus_err,
  output logic              inact_evt,
  output logic [7:0]        inact_port
);

  word_class_t       w_cls;
  eop_t              w_code;
  logic [PORT_W-1:0] w_port;
  logic              w_sop;
  logic              lk_active;
  logic [DEST_W-1:0] lk_dest;
  logic              take, take_first, take_sop, take_err, close;
  logic [DEST_W-1:0] take_dest;
  logic              seq_open, seq_need;

  cwd_classify u_classify (
    .word    (in_word),
    .ctl     (in_ctl),
    .cls     (w_cls),
    .code    (w_code),
    .port    (w_port),
    .sop_bit (w_sop)
  );

  cwd_port_map #(.DEST_W(DEST_W)) u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (map_we),
    .waddr   (map_port),
    .wactive (map_active),
    .wdest   (map_dest),
    .raddr   (w_port),
    .ractive (lk_active),
    .rdest   (lk_dest)
  );

  cwd_sequencer #(.DEST_W(DEST_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_sync    (in_sync),
    .cls        (w_cls),
    .code       (w_code),
    .sop_bit    (w_sop),
    .port       (w_port),
    .map_active (lk_active),
    .map_dest   (lk_dest),
    .take       (take),
    .take_first (take_first),
    .take_sop   (take_sop),
    .take_err   (take_err),
    .take_dest  (take_dest),
    .close      (close),
    .burst_open (seq_open),
    .need_data  (seq_need),
    .bus_err    (bus_err),
    .inact_evt  (inact_evt),
    .inact_port (inact_port)
  );

  cwd_stager #(.DEST_W(DEST_W), .LEN_W(LEN_W)) u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .drop       (!in_sync),
    .take       (take),
    .take_first (take_first),
    .take_sop   (take_sop),
    .take_err   (take_err),
    .take_dest  (take_dest),
    .take_data  (in_word),
    .close      (close),
    .close_code (w_code),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_dest   (out_dest),
    .out_sop    (out_sop),
    .out_eop    (out_eop),
    .out_len    (out_len),
    .out_err    (out_err)
  );

endmodule

// File: rtl/cwd_checker.sv
module cwd_checker #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ctl,
  input logic             in_sync,
  input logic [15:0]      in_word,
  input logic             burst_open,
  input logic             need_data,
  input logic             out_valid,
  input logic             out_eop,
  input logic [LEN_W-1:0] out_len,
  input logic             bus_err,
  input logic             inact_evt,
  input logic [7:0]       inact_port
);

  p_reserved_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sync && in_ctl && !in_word[15] && in_word[12]) |=> bus_err);

  p_missing_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sync && in_ctl && need_data) |=> bus_err);

  p_orphan_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sync && !in_ctl && !burst_open) |=> (bus_err && !out_valid));

  p_mid_no_eop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(in_ctl)) |-> !out_eop);

  p_len_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len != '0));

  p_inact_port_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inact_evt |-> (inact_port == $past(in_word[11:4]) && $past(in_ctl)));

  p_unsync_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_sync |=> (!out_valid && !bus_err && !inact_evt));

endmodule

bind ctl_word_dispatch cwd_checker #(.LEN_W(LEN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ctl     (in_ctl),
  .in_sync    (in_sync),
  .in_word    (in_word),
  .burst_open (seq_open),
  .need_data  (seq_need),
  .out_valid  (out_valid),
  .out_eop    (out_eop),
  .out_len    (out_len),
  .bus_err    (bus_err),
  .inact_evt  (inact_evt),
  .inact_port (inact_port)
);

// File: tb/ctl_word_dispatch_bench.sv
`timescale 1ns/1ps
module ctl_word_dispatch_bench;

  localparam int DW = 3;
  localparam int LW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0, in_ctl = 1'b0, in_sync = 1'b1;
  logic [15:0]   in_word = '0;
  logic          map_we = 1'b0, map_active = 1'b0;
  logic [7:0]    map_port = '0;
  logic [DW-1:0] map_dest = '0;
  logic          out_valid, out_sop, out_eop, out_err, bus_err, inact_evt;
  logic [15:0]   out_data;
  logic [DW-1:0] out_dest;
  logic [LW-1:0] out_len;
  logic [7:0]    inact_port;

  int total = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ctl_word_dispatch #(.DEST_W(DW), .LEN_W(LW)) u_ctl_word_dispatch (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ctl(in_ctl), .in_sync(in_sync),
    .in_word(in_word), .map_we(map_we), .map_port(map_port), .map_active(map_active),
    .map_dest(map_dest), .out_valid(out_valid), .out_data(out_data), .out_dest(out_dest),
    .out_sop(out_sop), .out_eop(out_eop), .out_len(out_len), .out_err(out_err),
    .bus_err(bus_err), .inact_evt(inact_evt), .inact_port(inact_port)
  );

  function automatic bit port_on(input int p);
    return (p % 3) != 0;
  endfunction

  function automatic logic [DW-1:0] port_dest(input int p);
    return DW'(p % 8);
  endfunction

  function automatic logic [15:0] pay(input int p, input bit sop, input logic [1:0] code);
    return {1'b1, code, sop, 8'(p), 4'h0};
  endfunction

  function automatic logic [15:0] idl(input logic [1:0] code);
    return {1'b0, code, 1'b0, 12'h5A5};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w, input logic c);
    in_word  = w;
    in_ctl   = c;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic gap();
    @(negedge clk);
  endtask

  task automatic map_write(input int p, input bit act, input logic [DW-1:0] d);
    map_we = 1'b1; map_port = 8'(p); map_active = act; map_dest = d;
    @(negedge clk);
    map_we = 1'b0;
  endtask

  task automatic quiet(input string req);
    chk({req, " out_valid"}, 32'(out_valid), 0);
    chk({req, " bus_err"},   32'(bus_err),   0);
  endtask

  task automatic expect_word(input string req, input logic [15:0] d, input logic [DW-1:0] dst,
                             input bit sop, input bit eop, input int len, input bit err);
    chk({req, " out_valid"}, 32'(out_valid), 1);
    chk({req, " out_data"},  32'(out_data),  32'(d));
    chk({req, " out_dest"},  32'(out_dest),  32'(dst));
    chk({req, " out_sop"},   32'(out_sop),   32'(sop));
    chk({req, " out_eop"},   32'(out_eop),   32'(eop));
    chk({req, " out_len"},   32'(out_len),   32'(len));
    chk({req, " out_err"},   32'(out_err),   32'(err));
  endtask

  task automatic resync();
    in_sync = 1'b0; gap(); in_sync = 1'b1; gap();
  endtask

  initial begin
    #800000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 out_valid", 32'(out_valid), 0);
    chk("R12 bus_err", 32'(bus_err), 0);
    chk("R12 inact_evt", 32'(inact_evt), 0);
    chk("R12 inact_port", 32'(inact_port), 0);
    rst_n = 1'b1;
    gap();
    // R12 every entry starts inactive
    send(pay(4, 1, 2'b00), 1'b1);
    chk("R12 map empty inact_evt", 32'(inact_evt), 1);
    send(16'h1234, 1'b0);
    quiet("R12 dropped data");
    send(idl(2'b10), 1'b1);
    quiet("R12 close");

    for (int p = 0; p < 256; p++) map_write(p, port_on(p), port_dest(p));

    // R4 R5 R6 R7 R9 sweep over every port
    for (int p = 0; p < 256; p++) begin
      logic [1:0] code;
      code = (p % 2 == 1) ? 2'b10 : 2'b11;
      d = {8'(p), ~8'(p)};
      send(pay(p, 1, 2'b00), 1'b1);
      chk("R9 inact_evt", 32'(inact_evt), 32'(!port_on(p)));
      if (!port_on(p)) chk("R9 inact_port", 32'(inact_port), 32'(p));
      quiet("R4 after payload");
      send(d, 1'b0);
      quiet("R4 data held");
      send(idl(code), 1'b1);
      if (port_on(p)) expect_word("R4 R6 R7 sweep", d, port_dest(p), 1, 1, (code == 2'b11) ? 1 : 2, 0);
      else quiet("R9 inactive discard");
    end

    // R5 R7 four-word burst ending on one byte
    send(pay(1, 1, 2'b00), 1'b1);
    for (int k = 1; k <= 4; k++) begin
      send(16'(16'hA000 + k), 1'b0);
      if (k == 1) quiet("R4 first held");
      else expect_word("R7 mid", 16'(16'hA000 + k - 1), port_dest(1), k == 2, 0, 2 * (k - 1), 0);
    end
    send(idl(2'b11), 1'b1);
    expect_word("R7 end one byte", 16'hA004, port_dest(1), 0, 1, 7, 0);
    // R5 continuation burst without SOP, R6 status 00 leaves packet open
    send(pay(2, 0, 2'b00), 1'b1);
    send(16'hB001, 1'b0);
    send(idl(2'b00), 1'b1);
    expect_word("R6 no end", 16'hB001, port_dest(2), 0, 0, 2, 0);
    // R4 payload word closes the previous burst and switches destination
    send(pay(1, 1, 2'b00), 1'b1);
    send(16'hC001, 1'b0);
    send(pay(5, 1, 2'b10), 1'b1);
    expect_word("R4 switch close", 16'hC001, port_dest(1), 1, 1, 2, 0);
    send(16'hC002, 1'b0);
    send(idl(2'b10), 1'b1);
    expect_word("R4 switch dest", 16'hC002, port_dest(5), 1, 1, 2, 0);

    // R1 sweep of non-payload upper nibbles
    for (int n = 0; n < 8; n++) begin
      send({4'(n), 12'h000}, 1'b1);
      chk("R1 reserved flag", 32'(bus_err), 32'(n % 2));
      chk("R1 no output", 32'(out_valid), 0);
    end
    resync();   // R10 clears any abort mark left by the sweep

    // R3 data with no burst
    send(16'hDEAD, 1'b0);
    chk("R3 orphan bus_err", 32'(bus_err), 1);
    chk("R3 orphan out", 32'(out_valid), 0);
    // R2 payload then control
    send(pay(1, 1, 2'b00), 1'b1);
    quiet("R2 payload");
    send(idl(2'b10), 1'b1);
    chk("R2 missing data", 32'(bus_err), 1);
    send(pay(1, 1, 2'b00), 1'b1);
    send(pay(2, 1, 2'b00), 1'b1);
    chk("R2 payload after payload", 32'(bus_err), 1);
    send(16'hE001, 1'b0);
    chk("R2 data ok", 32'(bus_err), 0);
    send(idl(2'b10), 1'b1);
    expect_word("R2 recovered", 16'hE001, port_dest(2), 1, 1, 2, 0);

    // R8 abort marks next packet only
    send(pay(1, 1, 2'b00), 1'b1);
    send(16'hF001, 1'b0);
    send(idl(2'b01), 1'b1);
    expect_word("R8 aborted packet", 16'hF001, port_dest(1), 1, 1, 2, 0);
    send(pay(2, 1, 2'b00), 1'b1);
    send(16'hF002, 1'b0);
    send(16'hF003, 1'b0);
    expect_word("R8 marked first", 16'hF002, port_dest(2), 1, 0, 2, 1);
    send(idl(2'b10), 1'b1);
    expect_word("R8 marked last", 16'hF003, port_dest(2), 0, 1, 4, 1);
    send(pay(4, 1, 2'b00), 1'b1);
    send(16'hF004, 1'b0);
    send(idl(2'b10), 1'b1);
    expect_word("R8 clean again", 16'hF004, port_dest(4), 1, 1, 2, 0);

    // R10 ignored while out of sync
    in_sync = 1'b0;
    send(pay(3, 1, 2'b00), 1'b1);
    chk("R10 no inact_evt", 32'(inact_evt), 0);
    send(pay(1, 1, 2'b00), 1'b1);
    send(16'h7001, 1'b0);
    send(idl(2'b10), 1'b1);
    quiet("R10 unsynced");
    in_sync = 1'b1;
    // R10 held word dropped by a sync loss mid burst
    send(pay(1, 1, 2'b00), 1'b1);
    send(16'h7002, 1'b0);
    send(16'h7003, 1'b0);
    expect_word("R10 before loss", 16'h7002, port_dest(1), 1, 0, 2, 0);
    in_sync = 1'b0; gap(); in_sync = 1'b1;
    send(idl(2'b10), 1'b1);
    quiet("R10 held dropped");
    send(16'h7004, 1'b0);
    chk("R10 burst cleared", 32'(bus_err), 1);

    // R11 map rewrites
    map_write(1, 0, 3'd0);
    send(pay(1, 1, 2'b00), 1'b1);
    chk("R11 now inactive", 32'(inact_evt), 1);
    chk("R11 port", 32'(inact_port), 1);
    send(16'h8001, 1'b0);
    quiet("R11 discard");
    send(idl(2'b10), 1'b1);
    quiet("R11 close");
    map_write(3, 1, 3'd5);
    send(pay(3, 1, 2'b00), 1'b1);
    chk("R11 now active", 32'(inact_evt), 0);
    send(16'h8002, 1'b0);
    send(idl(2'b10), 1'b1);
    expect_word("R11 new dest", 16'h8002, 3'd5, 1, 1, 2, 0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule